// File: doc/BRIEF.md
# Sticky RTC Status Flag Register

This block keeps three sticky status flags for a real-time clock: a power-up flag, a supply-warning flag and a crystal-halt flag. A one-cycle power-on event pulse and a one-cycle oscillator-halt pulse set them. Once set, a flag stays set until software writes a zero to its bit. Writing a one to a flag has no effect.

The supply-warning flag is a summary flag. It is raised whenever either of the other two events happens. Firmware reads it at boot to decide whether the clock must be reinitialised.

The crystal-halt flag sits in its own storage domain. Neither the block reset nor a power-on pulse touches it, so an oscillator failure stays visible after a power-up. Software reaches all three flags through one byte on a small register bus, with combinational reads and writes that take effect on the next clock edge.

Top module: `rtc_status_flags`

## Requirements
- R1: While `rst_n` is low, the power-up flag (bit 7) and the supply-warning flag (bit 2) are cleared. A read of the flag address then returns 0 in bits 7 to 1.
- R2: A cycle with `por_pulse` high sets bit 7 and bit 2 of the flag byte from the next clock edge on.
- R3: A cycle with `osc_stop_pulse` high sets bit 0 and bit 2 of the flag byte from the next clock edge on.
- R4: A set flag keeps reading 1 for as long as no clearing write reaches it.
- R5: A write at the flag address clears, at the next edge, every implemented flag whose `bus_wdata` bit is 0. Flags whose `bus_wdata` bit is 1 keep their value.
- R6: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up at 1.
- R7: Bit 0 keeps its value through a `por_pulse` and through an assertion of `rst_n`.
- R8: Bits 6, 5, 4, 3 and 1 of `bus_rdata` always read 0, and writes to them have no effect.
- R9: Writes to any address other than `FLAG_ADDR` (default 4'hE) leave all flags unchanged. Reads at any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset for bits 7 and 2 |
| por_pulse | input | 1 | One-cycle power-on event |
| osc_stop_pulse | input | 1 | One-cycle crystal-halt detection |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data; a 0 clears the matching flag |
| bus_rdata | output | 8 | Combinational read data |

## Verification
Two situations are hard to reach from the ports.

The first is a set event and a software clear landing on the same flag in the same clock cycle. The bench reaches it by driving the event pulses and a write together in a single cycle, for all four event combinations and for both all-clear and all-keep write data.

The second is the crystal-halt bit surviving a power-on pulse and a reset. The bench sets that bit first, then applies the power-on pulse and the reset while checking bit 0 after each. It repeats this with the bit cleared, so that the power-on pulse cannot set it either.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
    localparam int FLAG_W  = 8;
    localparam int POR_POS = 7;
    localparam int VLF_POS = 2;
    localparam int XST_POS = 0;
    localparam logic [FLAG_W-1:0] IMPL_MASK =
        FLAG_W'((1 << POR_POS) | (1 << VLF_POS) | (1 << XST_POS));

    typedef struct packed {
        logic pwr;
        logic low;
        logic halt;
    } flag_vec_t;
endpackage

// File: rtl/rtc_flag_decode.sv
module rtc_flag_decode
    import rtc_flag_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hE
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic              sel_o,
    output flag_vec_t         clr_o
);
    logic hit_d;

    always_comb begin
        hit_d      = (addr_i == FLAG_ADDR);
        sel_o      = hit_d;
        clr_o.pwr  = hit_d && we_i && !wdata_i[POR_POS];
        clr_o.low  = hit_d && we_i && !wdata_i[VLF_POS];
        clr_o.halt = hit_d && we_i && !wdata_i[XST_POS];
    end
endmodule

// File: rtl/rtc_sticky_bit.sv
module rtc_sticky_bit #(
    parameter bit KEEP_ON_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;
    logic q_q;

    always_comb begin
        q_d = q_q;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;
    end

    generate
        if (KEEP_ON_RESET) begin : g_keep
            always_ff @(posedge clk) begin
                q_q <= q_d;
            end
        end else begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_q <= 1'b0;
                else        q_q <= q_d;
            end
        end
    endgenerate

    assign q_o = q_q;

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && q_o) |=> q_o);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtc_flag_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_pulse,
    input  logic              osc_stop_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    flag_vec_t set_d;
    flag_vec_t clr_d;
    flag_vec_t flag_q;
    logic      sel_d;

    rtc_flag_decode #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_dec (
        .addr_i (bus_addr),
        .we_i   (bus_we),
        .wdata_i(bus_wdata),
        .sel_o  (sel_d),
        .clr_o  (clr_d)
    );

    always_comb begin
        set_d.pwr  = por_pulse;
        set_d.low  = por_pulse | osc_stop_pulse;
        set_d.halt = osc_stop_pulse;
    end

    rtc_sticky_bit #(.KEEP_ON_RESET(1'b0)) u_pwr (
        .clk(clk), .rst_n(rst_n), .set_i(set_d.pwr), .clr_i(clr_d.pwr), .q_o(flag_q.pwr));
    rtc_sticky_bit #(.KEEP_ON_RESET(1'b0)) u_low (
        .clk(clk), .rst_n(rst_n), .set_i(set_d.low), .clr_i(clr_d.low), .q_o(flag_q.low));
    rtc_sticky_bit #(.KEEP_ON_RESET(1'b1)) u_halt (
        .clk(clk), .rst_n(rst_n), .set_i(set_d.halt), .clr_i(clr_d.halt), .q_o(flag_q.halt));

    always_comb begin
        bus_rdata = '0;
        if (sel_d) begin
            bus_rdata[POR_POS] = flag_q.pwr;
            bus_rdata[VLF_POS] = flag_q.low;
            bus_rdata[XST_POS] = flag_q.halt;
        end
    end

    assert_por_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> (flag_q.pwr && flag_q.low));
    assert_osc_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_pulse |=> (flag_q.halt && flag_q.low));
    assert_halt_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (por_pulse && !osc_stop_pulse && !clr_d.halt) |=> $stable(flag_q.halt));
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == 8'h00);
    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != FLAG_ADDR && !por_pulse && !osc_stop_pulse)
        |=> $stable(flag_q));
endmodule

// File: tb/tb_rtc_status_flags.sv
`timescale 1ns/1ps
module tb_rtc_status_flags;
    localparam logic [3:0] FA = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_pulse = 1'b0;
    logic       osc_stop_pulse = 1'b0;
    logic [3:0] bus_addr = FA;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    rtc_status_flags dut (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse),
        .osc_stop_pulse(osc_stop_pulse), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    // one cycle of stimulus, driven after a falling edge; returns idle after the next falling edge
    task automatic cyc(input logic p, input logic o, input logic we,
                       input logic [3:0] a, input logic [7:0] w);
        @(negedge clk);
        por_pulse = p; osc_stop_pulse = o; bus_we = we; bus_addr = a; bus_wdata = w;
        @(negedge clk);
        por_pulse = 1'b0; osc_stop_pulse = 1'b0; bus_we = 1'b0; bus_addr = FA;
    endtask

    task automatic chk(input string req, input logic [3:0] a,
                       input logic [7:0] mask, input logic [7:0] exp);
        bus_addr = a;
        #1;
        total++;
        if ((bus_rdata & mask) !== (exp & mask)) begin
            bad++;
            $display("FAIL %s: rdata=%02h expected=%02h (mask %02h)", req, bus_rdata, exp, mask);
        end
        bus_addr = FA;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", FA, 8'hFE, 8'h00);
        rst_n = 1'b1;
        cyc(0, 0, 1, FA, 8'h00);
        chk("R1", FA, 8'hFF, 8'h00);
        // R2 power-on pulse sets bits 7 and 2
        cyc(1, 0, 0, FA, 8'h00);
        chk("R2", FA, 8'hFF, 8'h84);
        // R4 hold
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R4", FA, 8'hFF, 8'h84);
        end
        // R5 clear by zero, ignore one
        cyc(0, 0, 1, FA, 8'h04);
        chk("R5", FA, 8'hFF, 8'h04);
        cyc(0, 0, 1, FA, 8'hFF);
        chk("R5", FA, 8'hFF, 8'h04);
        cyc(0, 0, 1, FA, 8'h00);
        chk("R5", FA, 8'hFF, 8'h00);
        // R3 oscillator halt sets bits 0 and 2
        cyc(0, 1, 0, FA, 8'h00);
        chk("R3", FA, 8'hFF, 8'h05);
        // R7 halt bit survives power-on pulse
        cyc(1, 0, 0, FA, 8'h00);
        chk("R7", FA, 8'hFF, 8'h85);
        // R7 halt bit survives reset while others clear
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R7", FA, 8'hFF, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", FA, 8'hFF, 8'h01);
        // R7 power-on pulse does not set a cleared halt bit
        cyc(0, 0, 1, FA, 8'h00);
        cyc(1, 0, 0, FA, 8'h00);
        chk("R7", FA, 8'hFF, 8'h84);
        // R9 foreign address
        for (int a = 0; a < 16; a++) begin
            if (a[3:0] == FA) continue;
            cyc(0, 0, 1, a[3:0], 8'h00);
            chk("R9", FA, 8'hFF, 8'h84);
            chk("R9", a[3:0], 8'hFF, 8'h00);
        end
        // R6 set vs clear in the same cycle, all event combinations
        for (int k = 0; k < 8; k++) begin
            logic p, o;
            logic [7:0] w;
            logic [7:0] e;
            p = k[0]; o = k[1]; w = k[2] ? 8'hFF : 8'h00;
            cyc(0, 0, 1, FA, 8'h00);
            cyc(p, o, 1, FA, w);
            e = (p ? 8'h80 : 8'h00) | ((p | o) ? 8'h04 : 8'h00) | (o ? 8'h01 : 8'h00);
            chk("R6", FA, 8'hFF, e);
        end
        // R5/R8 sweep of every write pattern from all-set state
        for (int w = 0; w < 256; w++) begin
            cyc(1, 1, 0, FA, 8'h00);
            cyc(0, 0, 1, FA, w[7:0]);
            chk("R8", FA, 8'hFF, w[7:0] & 8'h85);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule